// File: doc/BRIEF.md
# Four-Lane Word Serializer with Lead/Follow Phase Alignment

The block takes four parallel sample words, lanes A to D, that a slower source refreshes once every four fast-clock cycles. It sends them out one per fast cycle on a single word bus. A two-bit lane counter, clocked by the fast clock, acts as a divide-by-2 and divide-by-4 select. The counter steers the output multiplexer and also produces a quarter-rate word clock, which the data source uses to launch its words. The sample codes are offset binary with bit 11 as the most significant bit, and they pass through without change.

Two serializers can run on one fast clock and still stay in step. One runs in lead mode, where its lane counter runs freely and drives the word clock out. The other runs in follow mode. It watches the incoming word clock and snaps its own lane counter to that clock's phase. Both then present lane A in the same fast cycle. This matters, for example, when the two serializers carry the in-phase and quadrature halves of a modulated stream.

Top module: `quad_word_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_valid` is 0, `ser_word` is 0 and `word_clk_out` is 1.
- R2: Every word on `ser_word` equals, bit for bit, an input word that was captured. No lane is altered or swapped.
- R3: Within each word-clock period the output order is A, B, C, D. Lane A appears in the second of the two cycles in which `word_clk_out` is high. Lanes B and C appear in the two low cycles, and lane D appears in the first high cycle of the following period.
- R4: `word_clk_out` has a period of four fast cycles: high for two cycles, then low for two. The first rising clock edge after reset is released ends its first high cycle.
- R5: The four lane inputs are sampled together at the fast edge that closes the second high cycle of `word_clk_out`. That group is emitted in the next word-clock period.
- R6: A change on the lane inputs at any other edge of the period has no effect on the output. The output only ever carries whole sampled groups.
- R7: With `mode_lead` = 1 (lead mode), `word_clk_in` has no effect.
- R8: With `mode_lead` = 0 (follow mode), a rising level on `word_clk_in` seen at a fast edge forces the lane counter to the phase that a lead instance holds one cycle after its own word-clock rise. If `word_clk_in` is wired directly from a lead instance on the same fast clock, the follower's `word_clk_out` matches the leader's, and both show lane A in the same cycle.
- R9: `ser_valid` stays 0 after reset until lane A of the first sampled group reaches the output. In lead mode this happens at the fifth rising edge after reset release. In follow mode it also waits for the first alignment edge, and only groups sampled after that edge count. Once high, `ser_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, one output word per cycle |
| rst_n | input | 1 | Active-low reset |
| mode_lead | input | 1 | 1 = lead (free-running counter), 0 = follow (aligned to `word_clk_in`) |
| word_clk_in | input | 1 | Quarter-rate word clock from a partner; used only in follow mode |
| word_clk_out | output | 1 | Quarter-rate word clock derived from the lane counter |
| chan_a | input | 12 | Lane A sample, offset binary |
| chan_b | input | 12 | Lane B sample |
| chan_c | input | 12 | Lane C sample |
| chan_d | input | 12 | Lane D sample |
| ser_word | output | 12 | Serialized word |
| ser_valid | output | 1 | High once the serialized stream carries sampled groups |

## Verification
The hardest case to produce is a follower whose counter starts out of phase with the leader and is then pulled into step by one edge. It is also hard to show that the follower discards everything it sampled before that edge. The bench releases the follower's reset two cycles after the leader's, so the follower's counter runs half a period away from the leader until the first rising edge of the leader's word clock arrives. The follower's lane inputs carry the bitwise complement of the leader's. Each follower word can then be checked against the leader word shown in the same cycle. At the same time, the bench puts random garbage on the lanes between sampling edges and toggles the leader's unused `word_clk_in` at random.

// File: rtl/qws_pkg.sv
package qws_pkg;

    localparam int unsigned LANES = 4;

    typedef logic [1:0] lane_t;

    localparam lane_t LANE_A = 2'd0;
    localparam lane_t LANE_B = 2'd1;
    localparam lane_t LANE_C = 2'd2;
    localparam lane_t LANE_D = 2'd3;

    // Phase at which the inputs are sampled and at which the group moves on
    localparam lane_t SAMPLE_PH = LANE_B;
    localparam lane_t SWAP_PH   = LANE_D;
    // Phase a follower jumps to on a detected word-clock rise
    localparam lane_t SNAP_PH   = LANE_B;

    typedef struct packed {
        lane_t ph;
        logic  wck_seen;
        logic  locked;
    } phase_st_t;

endpackage

// File: rtl/qws_phase_gen.sv
module qws_phase_gen
    import qws_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lead,
    input  logic  wck_in,
    output lane_t phase,
    output logic  locked,
    output logic  wck_out
);

    phase_st_t st_d, st_q;
    logic      wck_rise;

    always_comb begin
        st_d          = st_q;
        st_d.wck_seen = wck_in;
        wck_rise      = wck_in & ~st_q.wck_seen;
        if (!lead && wck_rise) begin
            st_d.ph     = SNAP_PH;
            st_d.locked = 1'b1;
        end else begin
            st_d.ph = st_q.ph + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase   = st_q.ph;
    assign locked  = lead | st_q.locked;
    assign wck_out = ~st_q.ph[1];

    assert_lead_free_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> (st_q.ph == $past(st_q.ph) + 2'd1));

    assert_follow_snap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead && wck_in && !st_q.wck_seen) |=> (st_q.ph == SNAP_PH && st_q.locked));

endmodule

// File: rtl/qws_capture.sv
module qws_capture
    import qws_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lane_t                   phase,
    input  logic                    locked,
    input  logic [LANES-1:0][W-1:0] din,
    output logic [LANES-1:0][W-1:0] group,
    output logic                    group_ok
);

    typedef struct packed {
        logic [LANES-1:0][W-1:0] smp;
        logic [LANES-1:0][W-1:0] grp;
        logic                    smp_ok;
        logic                    grp_ok;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase == SAMPLE_PH) begin
            st_d.smp    = din;
            st_d.smp_ok = st_q.smp_ok | locked;
        end
        if (phase == SWAP_PH) begin
            st_d.grp    = st_q.smp;
            st_d.grp_ok = st_q.grp_ok | st_q.smp_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign group    = st_q.grp;
    assign group_ok = st_q.grp_ok;

    assert_group_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != SWAP_PH) |=> $stable(st_q.grp));

    assert_group_ok_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.grp_ok |=> st_q.grp_ok);

endmodule

// File: rtl/qws_lane_mux.sv
module qws_lane_mux
    import qws_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lane_t                   phase,
    input  logic [LANES-1:0][W-1:0] group,
    input  logic                    group_ok,
    output logic [W-1:0]            word,
    output logic                    valid
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         valid;
    } mux_st_t;

    mux_st_t st_d, st_q;

    always_comb begin
        st_d.word  = group[phase];
        st_d.valid = group_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word  = st_q.word;
    assign valid = st_q.valid;

    assert_valid_starts_on_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> ($past(phase) == LANE_A));

endmodule

// File: rtl/quad_word_serializer.sv
module quad_word_serializer
    import qws_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk_fast,
    input  logic         rst_n,
    input  logic         mode_lead,
    input  logic         word_clk_in,
    output logic         word_clk_out,
    input  logic [W-1:0] chan_a,
    input  logic [W-1:0] chan_b,
    input  logic [W-1:0] chan_c,
    input  logic [W-1:0] chan_d,
    output logic [W-1:0] ser_word,
    output logic         ser_valid
);

    lane_t                   phase;
    logic                    locked;
    logic [LANES-1:0][W-1:0] din;
    logic [LANES-1:0][W-1:0] group;
    logic                    group_ok;

    assign din = {chan_d, chan_c, chan_b, chan_a};

    qws_phase_gen u_phase (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .lead    (mode_lead),
        .wck_in  (word_clk_in),
        .phase   (phase),
        .locked  (locked),
        .wck_out (word_clk_out)
    );

    qws_capture #(.W(W)) u_capture (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .phase    (phase),
        .locked   (locked),
        .din      (din),
        .group    (group),
        .group_ok (group_ok)
    );

    qws_lane_mux #(.W(W)) u_mux (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .phase    (phase),
        .group    (group),
        .group_ok (group_ok),
        .word     (ser_word),
        .valid    (ser_valid)
    );

    assert_wck_period_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (mode_lead && $rose(word_clk_out)) |=> (word_clk_out && !$stable(phase)));

endmodule

// File: tb/quad_word_serializer_tb_top.sv
module quad_word_serializer_tb_top;

    localparam int W = 12;
    localparam int RUN_CYCLES = 1200;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_m_n, rst_s_n, wck_junk;
    logic wck_m, wck_s;
    logic [W-1:0] a_m, b_m, c_m, d_m;
    logic [W-1:0] ser_m, ser_s;
    logic val_m, val_s;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    quad_word_serializer #(.W(W)) dut_i (
        .clk_fast(clk), .rst_n(rst_m_n), .mode_lead(1'b1),
        .word_clk_in(wck_junk), .word_clk_out(wck_m),
        .chan_a(a_m), .chan_b(b_m), .chan_c(c_m), .chan_d(d_m),
        .ser_word(ser_m), .ser_valid(val_m));

    quad_word_serializer #(.W(W)) dut_follow_i (
        .clk_fast(clk), .rst_n(rst_s_n), .mode_lead(1'b0),
        .word_clk_in(wck_m), .word_clk_out(wck_s),
        .chan_a(~a_m), .chan_b(~b_m), .chan_c(~c_m), .chan_d(~d_m),
        .ser_word(ser_s), .ser_valid(val_s));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4*W-1:0] make_group(input int g);
        case (g)
            0: return '0;
            1: return '1;
            2: return {12'hFFE, 12'h001, 12'h7FF, 12'h800};
            3: return {12'h5A5, 12'hA5A, 12'hF0F, 12'h0F0};
            default: return {$urandom()} [4*W-1:0] ^ {$urandom(), 16'h0} ;
        endcase
    endfunction

    // Lane A position: word_clk_out high now and in the previous cycle
    function automatic bit a_slot(input logic now, input logic prev);
        return now && prev;
    endfunction

    logic [W-1:0] exp_q[$];

    initial begin
        void'($urandom(32'd1234));
        rst_m_n = 1'b0; rst_s_n = 1'b0; wck_junk = 1'b0;
        {d_m, c_m, b_m, a_m} = '0;
        repeat (3) @(negedge clk);
        // R1 reset state on both instances
        check(val_m == 1'b0 && val_s == 1'b0, "R1 valid", {val_s, val_m}, 0);
        check(ser_m == '0 && ser_s == '0, "R1 word", int'(ser_m) | int'(ser_s), 0);
        check(wck_m == 1'b1 && wck_s == 1'b1, "R1 word clock", {wck_s, wck_m}, 3);
        begin
            logic prev_m = 1'b0;
            int k = 0;
            int grp_no = 0;
            int words_m = 0;
            int words_s = 0;
            for (int i = 0; i < RUN_CYCLES; i++) begin
                if (i == 0) rst_m_n = 1'b1;
                if (i == 2) rst_s_n = 1'b1;
                #1;
                // R4 word clock shape of the leader
                if (i >= 1 && i < 48)
                    check(wck_m == ((i % 4) < 2), "R4 word clock", wck_m, ((i % 4) < 2));
                // R9 first valid of leader
                if (i >= 1 && i <= 4) check(val_m == 1'b0, "R9 lead valid early", val_m, 0);
                if (i == 5) check(val_m == 1'b1, "R9 lead valid onset", val_m, 1);
                // R9 follower waits for alignment and fresh samples
                if (i <= 8) check(val_s == 1'b0, "R9 follow valid early", val_s, 0);
                if (i == 9) check(val_s == 1'b1, "R9 follow valid onset", val_s, 1);
                // R2/R3/R5/R6/R7 leader stream
                if (val_m) begin
                    logic [W-1:0] e;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5 stream underrun", ser_m, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(ser_m == e, "R2 R6 R7 leader word", ser_m, e);
                    end
                    if (words_m % 4 == 0)
                        check(a_slot(wck_m, prev_m), "R3 lane A slot", {prev_m, wck_m}, 3);
                    words_m++;
                end
                // R8 follower tracks leader
                if (i >= 5)
                    check(wck_s == wck_m, "R8 word clock match", wck_s, wck_m);
                if (val_s) begin
                    check(val_m && (ser_s == ~ser_m), "R8 follower lane", ser_s, ~ser_m);
                    words_s++;
                end
                // stimulus
                wck_junk = $urandom() & 1;
                if (wck_m && !prev_m) begin
                    logic [4*W-1:0] g;
                    g = make_group(grp_no);
                    grp_no++;
                    {d_m, c_m, b_m, a_m} = g;
                    exp_q.push_back(a_m); exp_q.push_back(b_m);
                    exp_q.push_back(c_m); exp_q.push_back(d_m);
                    k = 0;
                end else begin
                    k++;
                    if (k == 2 && grp_no > 4) {d_m, c_m, b_m, a_m} = {$urandom(), $urandom()};
                end
                prev_m = wck_m;
                @(negedge clk);
            end
            check(words_m > 1000, "R2 leader words seen", words_m, 1000);
            check(words_s > 1000, "R8 follower words seen", words_s, 1000);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, RUN_CYCLES);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule